// File: doc/BRIEF.md
# Supply-Drift Duty Code Compensator

This block sits between a source of duty codes and a PWM generator whose output is low-pass filtered into an analog level. The PWM high level tracks the supply rail, so as a battery discharges the same duty code gives a smaller analog voltage. The block corrects for this. It keeps a gain factor equal to the nominal rail divided by the most recent rail measurement. It multiplies every duty code by that factor before the code leaves the block.

The gain is a fixed-point integer in which the value `RATIO_ONE` (default 1000) means unity. When a supply sample is taken, a bit-serial restoring divider computes `nominalMv * RATIO_ONE / supplyMv`. The divider runs over several cycles. While it runs, codes are still scaled with the previous gain. Each accepted code is multiplied by the gain in a 16x16 unsigned product. The product is divided by `RATIO_ONE` with round-half-up and then clipped to the top duty count. A sagging rail therefore shrinks the usable output range by the factor measured/nominal. For example, 2.8 V measured against 3.0 V nominal leaves about 93 % of the range.

Top module: `drift_code_comp`

## Requirements
- R1: After reset the gain is unity (1000), `outValid` is low and `inReady` is high, so a code passes through unchanged.
- R2: A code accepted on a rising edge (`inValid` and `inReady` both high) appears on `outCode` with `outValid` high after that same edge. Its value is `(code*gain + 500) / 1000` using integer division, clipped as in R3.
- R3: The output code never exceeds `MAX_CODE` (default 512). Any larger scaled result is replaced by exactly `MAX_CODE`.
- R4: A supply sample taken while the divider is idle sets the gain to `floor(nominalMv*1000 / supplyMv)` within 36 cycles. Later codes use the new gain. Example: nominal 3000 and sample 2800 give gain 1071, and code 256 becomes 274.
- R5: A supply sample of zero, or one greater than `nominalMv`, sets the gain to exactly 1000. A sample equal to `nominalMv` also gives 1000, so the gain never falls below 1000.
- R6: A quotient above 65535 is stored as 65535. Example: nominal 3000 and sample 1 give gain 65535, and code 7 becomes 459.
- R7: While the divider is computing, codes are scaled with the previous gain. Any supply sample presented during that time is ignored.
- R8: `inReady` equals `!outValid || outReady`. While `outValid` is high and `outReady` is low, `outValid` and `outCode` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| nominalMv | input | 16 | Nominal supply in millivolts, held constant |
| supplyValid | input | 1 | One-cycle strobe for a new supply sample |
| supplyMv | input | 16 | Measured supply in millivolts |
| inValid | input | 1 | Input duty code valid |
| inReady | output | 1 | Block can accept an input code |
| inCode | input | 16 | Uncorrected duty code |
| outValid | output | 1 | Corrected code valid |
| outReady | input | 1 | Downstream accepts the corrected code |
| outCode | output | 16 | Corrected, clipped duty code |

## Verification
The assertions assume that `nominalMv` stays constant between reset and the end of the run. A change while a quotient is being formed would leave the gain undefined, and the gain-floor property depends on the nominal value being fixed. They also assume that the downstream side obeys the ready rule, so held outputs are judged only while `outReady` is low. The stimulus programs 3000 mV once before reset is released and never changes it. Supply strobes last one cycle. Every gain-dependent code waits 40 cycles after a sample, except the codes that deliberately probe the old-gain window of R7.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef struct packed {
    logic loadDiv;
    logic stepDiv;
    logic commitDiv;
    logic setUnity;
  } compStrobe_t;
endpackage

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter int VOLT_W = 16,
  parameter int STEPS  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyValid,
  input  logic [VOLT_W-1:0] supplyMv,
  input  logic [VOLT_W-1:0] nominalMv,
  output compStrobe_t       strobe
);
  localparam int CNT_W = $clog2(STEPS);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} ctrlState_t;

  ctrlState_t stateQ;
  logic [CNT_W-1:0] stepCntQ;
  logic outOfRange;

  assign outOfRange = (supplyMv == '0) || (supplyMv > nominalMv);

  always_comb begin
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (supplyValid) begin
          if (outOfRange) strobe.setUnity = 1'b1;
          else            strobe.loadDiv  = 1'b1;
        end
      end
      ST_RUN:  strobe.stepDiv   = 1'b1;
      ST_DONE: strobe.commitDiv = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      stepCntQ <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          stepCntQ <= '0;
          if (strobe.loadDiv) stateQ <= ST_RUN;
        end
        ST_RUN: begin
          stepCntQ <= stepCntQ + 1'b1;
          if (stepCntQ == CNT_W'(STEPS - 1)) stateQ <= ST_DONE;
        end
        ST_DONE: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R4: a result is committed only straight after the last division step
  assert_commit_after_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitDiv |-> $past(strobe.stepDiv));

  // R7: a new division never starts while one is in progress
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepDiv |=> !strobe.loadDiv && !strobe.setUnity);
endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int VOLT_W    = 16,
  parameter int RATIO_W   = 16,
  parameter int RATIO_ONE = 1000,
  parameter int MAX_CODE  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  compStrobe_t       strobe,
  input  logic [VOLT_W-1:0] nominalMv,
  input  logic [VOLT_W-1:0] supplyMv,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CODE_W-1:0] inCode,
  output logic              outValid,
  input  logic              outReady,
  output logic [CODE_W-1:0] outCode
);
  localparam int DVD_W  = 2 * VOLT_W;
  localparam int PROD_W = CODE_W + RATIO_W;
  localparam int EXT_W  = PROD_W + 1;
  localparam logic [DVD_W-1:0]   RATIO_MAX_D = DVD_W'((64'd1 << RATIO_W) - 1);
  localparam logic [RATIO_W-1:0] RATIO_MAX   = '1;
  localparam logic [RATIO_W-1:0] UNITY       = RATIO_W'(RATIO_ONE);
  localparam logic [EXT_W-1:0]   DIV_EXT     = EXT_W'(RATIO_ONE);
  localparam logic [EXT_W-1:0]   HALF_EXT    = EXT_W'(RATIO_ONE / 2);
  localparam logic [EXT_W-1:0]   MAX_EXT     = EXT_W'(MAX_CODE);
  localparam logic [CODE_W-1:0]  MAX_OUT     = CODE_W'(MAX_CODE);

  // ---------------- gain divider ----------------
  logic [DVD_W-1:0]   dvdQ;
  logic [VOLT_W-1:0]  remQ;
  logic [VOLT_W-1:0]  divisorQ;
  logic [RATIO_W-1:0] ratioQ;
  logic [VOLT_W:0]    trial;
  logic [VOLT_W:0]    trialDiff;
  logic               trialGe;

  assign trial     = {remQ, dvdQ[DVD_W-1]};
  assign trialGe   = trial >= {1'b0, divisorQ};
  assign trialDiff = trial - {1'b0, divisorQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvdQ     <= '0;
      remQ     <= '0;
      divisorQ <= '0;
      ratioQ   <= UNITY;
    end else begin
      if (strobe.loadDiv) begin
        dvdQ     <= DVD_W'(nominalMv) * DVD_W'(RATIO_ONE);
        remQ     <= '0;
        divisorQ <= supplyMv;
      end else if (strobe.stepDiv) begin
        remQ <= trialGe ? trialDiff[VOLT_W-1:0] : trial[VOLT_W-1:0];
        dvdQ <= {dvdQ[DVD_W-2:0], trialGe};
      end
      if (strobe.commitDiv) begin
        ratioQ <= (dvdQ > RATIO_MAX_D) ? RATIO_MAX : dvdQ[RATIO_W-1:0];
      end else if (strobe.setUnity) begin
        ratioQ <= UNITY;
      end
    end
  end

  // ---------------- code scaler ----------------
  logic [PROD_W-1:0] product;
  logic [EXT_W-1:0]  rounded;
  logic [CODE_W-1:0] clipped;
  logic              outValidQ;
  logic [CODE_W-1:0] outCodeQ;

  assign product = PROD_W'(inCode) * PROD_W'(ratioQ);
  assign rounded = ({1'b0, product} + HALF_EXT) / DIV_EXT;
  assign clipped = (rounded > MAX_EXT) ? MAX_OUT : rounded[CODE_W-1:0];
  assign inReady = !outValidQ || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      outCodeQ  <= '0;
    end else if (inValid && inReady) begin
      outValidQ <= 1'b1;
      outCodeQ  <= clipped;
    end else if (outReady) begin
      outValidQ <= 1'b0;
    end
  end

  assign outValid = outValidQ;
  assign outCode  = outCodeQ;

  // R3: output never above full scale
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outCode <= MAX_OUT);

  // R5: the gain never drops below unity
  assert_gain_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    ratioQ >= UNITY);

  // R7: gain is untouched while the divider iterates
  assert_gain_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepDiv |=> $stable(ratioQ));

  // R8: stalled output holds
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outCode));
endmodule

// File: rtl/drift_code_comp.sv
module drift_code_comp
  import sdc_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int VOLT_W    = 16,
  parameter int RATIO_W   = 16,
  parameter int RATIO_ONE = 1000,
  parameter int MAX_CODE  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VOLT_W-1:0] nominalMv,
  input  logic              supplyValid,
  input  logic [VOLT_W-1:0] supplyMv,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CODE_W-1:0] inCode,
  output logic              outValid,
  input  logic              outReady,
  output logic [CODE_W-1:0] outCode
);
  localparam int STEPS = 2 * VOLT_W;

  compStrobe_t strobe;

  sdc_ctrl #(.VOLT_W(VOLT_W), .STEPS(STEPS)) ctrl_i (
    .clk(clk), .rstN(rstN), .supplyValid(supplyValid),
    .supplyMv(supplyMv), .nominalMv(nominalMv), .strobe(strobe)
  );

  sdc_datapath #(
    .CODE_W(CODE_W), .VOLT_W(VOLT_W), .RATIO_W(RATIO_W),
    .RATIO_ONE(RATIO_ONE), .MAX_CODE(MAX_CODE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nominalMv(nominalMv),
    .supplyMv(supplyMv), .inValid(inValid), .inReady(inReady),
    .inCode(inCode), .outValid(outValid), .outReady(outReady),
    .outCode(outCode)
  );
endmodule

// File: tb/drift_code_comp_tb_top.sv
module drift_code_comp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NOMINAL    = 3000;
  localparam int FULL       = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] nominalMv = 16'(NOMINAL);
  logic supplyValid = 1'b0;
  logic [15:0] supplyMv = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [15:0] inCode = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [15:0] outCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  drift_code_comp dut_i (
    .clk(clk), .rstN(rstN), .nominalMv(nominalMv), .supplyValid(supplyValid),
    .supplyMv(supplyMv), .inValid(inValid), .inReady(inReady), .inCode(inCode),
    .outValid(outValid), .outReady(outReady), .outCode(outCode)
  );

  typedef struct {
    int    expCode;
    string tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit stallMode = 1'b0;
  bit finished  = 1'b0;

  function automatic int gainFor(int measured);
    longint q;
    if (measured == 0 || measured > NOMINAL) return 1000;
    q = (longint'(NOMINAL) * 1000) / measured;
    if (q > 65535) q = 65535;
    return int'(q);
  endfunction

  function automatic int scaled(int code, int gain);
    longint r;
    r = (longint'(code) * gain + 500) / 1000;
    if (r > FULL) r = FULL;
    return int'(r);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendCode(int code, int gain, string tag);
    expItem_t it;
    it.expCode = scaled(code, gain);
    it.tag     = tag;
    scoreQ.push_back(it);
    @(negedge clk);
    inValid = 1'b1;
    inCode  = 16'(code);
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendSupply(int mv);
    @(negedge clk);
    supplyValid = 1'b1;
    supplyMv    = 16'(mv);
    @(negedge clk);
    supplyValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Downstream ready pattern, changed away from the edge
  int readyCnt = 0;
  always @(posedge clk) begin
    #2;
    readyCnt++;
    outReady = stallMode ? (readyCnt % 3 == 0) : 1'b1;
  end

  // Monitor: pops expected items and checks held outputs
  bit        wasStalled = 1'b0;
  logic [15:0] stallCode;
  always @(negedge clk) begin
    if (rstN) begin
      if (wasStalled) begin
        check(outValid && outCode == stallCode, "R8 hold", int'(outCode), int'(stallCode));
      end
      wasStalled = outValid && !outReady;
      stallCode  = outCode;
      check(inReady == (!outValid || outReady), "R8 ready", int'(inReady), int'(!outValid || outReady));
      if (outValid && outReady) begin
        if (scoreQ.size() == 0) begin
          check(1'b0, "R2 unexpected output", int'(outCode), -1);
        end else begin
          expItem_t it;
          it = scoreQ.pop_front();
          check(int'(outCode) == it.expCode, it.tag, int'(outCode), it.expCode);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int g;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady", int'(inReady), 1);
    sendCode(0, 1000, "R1 code0");
    sendCode(1, 1000, "R1 code1");
    sendCode(256, 1000, "R1 code256");
    sendCode(512, 1000, "R2 code512");
    sendCode(600, 1000, "R3 clip600");
    sendCode(65535, 1000, "R3 clipmax");

    // R4: measured 2800
    g = gainFor(2800);
    sendSupply(2800);
    idle(40);
    sendCode(256, g, "R4 code256");
    sendCode(100, g, "R4 code100");
    sendCode(511, g, "R3 clip511");
    sendCode(478, g, "R2 code478");

    // R5: equal, zero, above nominal
    sendSupply(3000); idle(40);
    sendCode(300, 1000, "R5 equal");
    sendSupply(1500); idle(40);
    sendCode(100, 2000, "R4 half");
    sendSupply(0); idle(40);
    sendCode(300, 1000, "R5 zero");
    sendSupply(1500); idle(40);
    sendSupply(3500); idle(40);
    sendCode(300, 1000, "R5 above");

    // R6: clamp
    sendSupply(1); idle(40);
    sendCode(1, 65535, "R6 code1");
    sendCode(7, 65535, "R6 code7");
    sendCode(8, 65535, "R6 code8");

    // R7: old gain in use while dividing; sample during run dropped
    sendSupply(2800);
    sendCode(3, 65535, "R7 oldgain");
    sendSupply(1500);
    idle(40);
    sendCode(256, gainFor(2800), "R7 dropped");
    sendCode(200, gainFor(2800), "R7 dropped2");

    // R8: back-pressure with a stream of codes
    stallMode = 1'b1;
    for (int k = 0; k < 20; k++) sendCode(20 * k + 3, gainFor(2800), "R8 stream");
    idle(20);
    stallMode = 1'b0;
    idle(10);
    check(scoreQ.size() == 0, "R2 drained", scoreQ.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule